// File: doc/BRIEF.md
# Inbound Message Admission Controller

This block sits at the receive side of an endpoint and decides how each incoming message, doorbell or port-write transaction is answered. It tracks six units: four mailboxes, one doorbell unit and one port-write unit. For each unit it keeps an occupancy counter, a sticky failed flag and a sticky error flag. Each unit's readiness and busy state arrive as live inputs.

A transaction is presented for one cycle with its kind, a mailbox index and a size-legal flag. One cycle later the block drives a single-cycle response code: accept, retry, error or discard. Discard means no response packet is sent. Error conditions are checked first, then retry conditions, and accept is the default. An accepted transaction occupies one slot of the unit. Local logic frees slots with a pop strobe, marks a unit failed with a fault strobe, and removes the failed and error states with a clear strobe.

The unit flags are shown as two read-only 32-bit status words. Bit 0 of each word is its most significant bit.

Top module: `msg_admit_ctrl`

## Requirements
- R1: `stat_mbox` holds one 8-bit group per mailbox. Mailbox n starts at bit 8n, where bit 0 is the MSB, so bit position k maps to vector index 31-k. Within a group the order is available, full, empty, busy, failed, error, then two reserved zero bits. Available and busy mirror `unit_ready`/`unit_busy`. Empty means the count is zero, and full means the count equals DEPTH.
- R2: `stat_dbpw` holds the doorbell group at bits 0–5 (vector 31..26) and the port-write group at bits 24–29 (vector 7..2), in the R1 flag order. All other bits read zero.
- R3: Unit indices are 0–3 for mailboxes, 4 for doorbell and 5 for port-write; `txn_kind` is 0 message, 1 doorbell, 2 port-write, 3 none. A message or doorbell gets error (code 2) when the target is not ready, failed or in error, or when `txn_size_ok` is low. This takes priority over every retry condition.
- R4: A message with no error condition gets retry (code 1) when the mailbox is full or busy.
- R5: With no error or retry condition the response is accept (code 0), and the unit count rises by one. The count never exceeds DEPTH.
- R6: A port-write never gets error or retry. Every error or full condition gives discard (code 3) instead.
- R7: A busy doorbell gives retry when DB_BUSY_RETRY is 1, otherwise busy is ignored. A busy port-write unit gives discard when PW_BUSY_DROP is 1, otherwise busy is ignored.
- R8: A transaction with `txn_size_ok` low sets the target's error flag. A fault strobe sets the failed flag. Both flags stay set until a clear strobe for that unit, and a set in the same cycle as a clear wins.
- R9: A pop strobe lowers the unit count by one. A pop at count zero has no effect. An accept and a pop in the same cycle leave the count unchanged unless the count was zero.
- R10: `resp_valid` pulses for exactly one cycle, one cycle after each strobe with kind 0–2. Kind 3 gives no response and changes no state.
- R11: After reset all counts are zero, the flags are clear and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Transaction strobe |
| txn_kind | input | 2 | 0 message, 1 doorbell, 2 port-write, 3 none |
| txn_mbox | input | 2 | Mailbox index for messages |
| txn_size_ok | input | 1 | Transaction size and form are legal |
| unit_ready | input | 6 | Per-unit initialized and ready |
| unit_busy | input | 6 | Per-unit busy receiving |
| pop_valid | input | 1 | Free one slot |
| pop_unit | input | 3 | Unit to pop |
| fault_valid | input | 1 | Mark a unit failed |
| fault_unit | input | 3 | Unit that faulted |
| clr_valid | input | 1 | Clear failed and error |
| clr_unit | input | 3 | Unit to clear |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 2 | 0 accept, 1 retry, 2 error, 3 discard |
| stat_mbox | output | 32 | Mailbox status word |
| stat_dbpw | output | 32 | Doorbell and port-write status word |

## Verification
The bench targets a unit that is both failed and full. A design with the wrong priority would answer retry instead of error. A port-write to a full or faulted unit is checked for discard, because a design that reused the message rule would send an error or retry response. The bench also checks that a bad-size transaction leaves a sticky error, so that later legal traffic to the same unit is still refused until a clear. It pops at zero and pushes and pops together at the depth limit, where a wrapping or double-counting counter would corrupt the empty and full bits.

// File: rtl/msg_admit_pkg.sv
package msg_admit_pkg;
    localparam int NUM_MBOX    = 4;
    localparam int NUM_UNITS   = 6;
    localparam int UNIT_W      = 3;
    localparam int UNIT_DBELL  = 4;
    localparam int UNIT_PWRITE = 5;

    typedef enum logic [1:0] {
        KIND_MSG    = 2'd0,
        KIND_DBELL  = 2'd1,
        KIND_PWRITE = 2'd2,
        KIND_NONE   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        RESP_ACCEPT  = 2'd0,
        RESP_RETRY   = 2'd1,
        RESP_ERROR   = 2'd2,
        RESP_DISCARD = 2'd3
    } resp_e;
endpackage

// File: rtl/msg_admit_unit.sv
module msg_admit_unit #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             pop_i,
    input  logic             fault_i,
    input  logic             clr_i,
    input  logic             size_err_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             failed_o,
    output logic             error_o,
    output logic             full_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             failed;
        logic             error;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        can_pop;

    always_comb begin
        st_d    = st_q;
        can_pop = pop_i && (st_q.cnt != '0);
        if (clr_i) begin
            st_d.failed = 1'b0;
            st_d.error  = 1'b0;
        end
        if (fault_i)    st_d.failed = 1'b1;
        if (size_err_i) st_d.error  = 1'b1;
        if (acc_i && !can_pop)      st_d.cnt = st_q.cnt + CNT_W'(1);
        else if (!acc_i && can_pop) st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign failed_o = st_q.failed;
    assign error_o  = st_q.error;
    assign full_o   = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o  = (st_q.cnt == '0);
endmodule

// File: rtl/msg_admit_decide.sv
module msg_admit_decide
    import msg_admit_pkg::*;
#(
    parameter bit DB_BUSY_RETRY = 1'b1,
    parameter bit PW_BUSY_DROP  = 1'b1
) (
    input  logic                 txn_valid,
    input  logic [1:0]           txn_kind,
    input  logic [1:0]           txn_mbox,
    input  logic                 txn_size_ok,
    input  logic [NUM_UNITS-1:0] ready,
    input  logic [NUM_UNITS-1:0] busy,
    input  logic [NUM_UNITS-1:0] failed,
    input  logic [NUM_UNITS-1:0] error,
    input  logic [NUM_UNITS-1:0] full,
    output logic [UNIT_W-1:0]    unit_idx,
    output logic                 respond,
    output logic                 accept,
    output logic [1:0]           code
);
    logic err_cond, retry_cond, busy_blocks;

    always_comb begin
        unit_idx = UNIT_W'(UNIT_PWRITE);
        case (kind_e'(txn_kind))
            KIND_MSG:   unit_idx = UNIT_W'(txn_mbox);
            KIND_DBELL: unit_idx = UNIT_W'(UNIT_DBELL);
            default:    unit_idx = UNIT_W'(UNIT_PWRITE);
        endcase

        busy_blocks = 1'b1;
        if (kind_e'(txn_kind) == KIND_DBELL)  busy_blocks = DB_BUSY_RETRY;
        if (kind_e'(txn_kind) == KIND_PWRITE) busy_blocks = PW_BUSY_DROP;

        err_cond   = !ready[unit_idx] || failed[unit_idx] || error[unit_idx] || !txn_size_ok;
        retry_cond = full[unit_idx] || (busy[unit_idx] && busy_blocks);

        respond = txn_valid && (kind_e'(txn_kind) != KIND_NONE);
        if (kind_e'(txn_kind) == KIND_PWRITE)
            code = (err_cond || retry_cond) ? RESP_DISCARD : RESP_ACCEPT;
        else if (err_cond)
            code = RESP_ERROR;
        else if (retry_cond)
            code = RESP_RETRY;
        else
            code = RESP_ACCEPT;
        accept = respond && (code == RESP_ACCEPT);
    end
endmodule

// File: rtl/msg_admit_status.sv
module msg_admit_status
    import msg_admit_pkg::*;
(
    input  logic [NUM_UNITS-1:0] ready,
    input  logic [NUM_UNITS-1:0] full,
    input  logic [NUM_UNITS-1:0] empty,
    input  logic [NUM_UNITS-1:0] busy,
    input  logic [NUM_UNITS-1:0] failed,
    input  logic [NUM_UNITS-1:0] error,
    output logic [31:0]          stat_mbox,
    output logic [31:0]          stat_dbpw
);
    function automatic logic [7:0] group(input int u, input logic [NUM_UNITS-1:0] rd,
                                         input logic [NUM_UNITS-1:0] fu,
                                         input logic [NUM_UNITS-1:0] em,
                                         input logic [NUM_UNITS-1:0] bs,
                                         input logic [NUM_UNITS-1:0] fl,
                                         input logic [NUM_UNITS-1:0] er);
        return {rd[u], fu[u], em[u], bs[u], fl[u], er[u], 2'b00};
    endfunction

    always_comb begin
        stat_mbox = '0;
        for (int m = 0; m < NUM_MBOX; m++)
            stat_mbox[31-8*m -: 8] = group(m, ready, full, empty, busy, failed, error);
        stat_dbpw = '0;
        stat_dbpw[31:24] = group(UNIT_DBELL, ready, full, empty, busy, failed, error);
        stat_dbpw[7:0]   = group(UNIT_PWRITE, ready, full, empty, busy, failed, error);
    end
endmodule

// File: rtl/msg_admit_ctrl.sv
module msg_admit_ctrl
    import msg_admit_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter bit DB_BUSY_RETRY = 1'b1,
    parameter bit PW_BUSY_DROP  = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_valid,
    input  logic [1:0]  txn_kind,
    input  logic [1:0]  txn_mbox,
    input  logic        txn_size_ok,
    input  logic [5:0]  unit_ready,
    input  logic [5:0]  unit_busy,
    input  logic        pop_valid,
    input  logic [2:0]  pop_unit,
    input  logic        fault_valid,
    input  logic [2:0]  fault_unit,
    input  logic        clr_valid,
    input  logic [2:0]  clr_unit,
    output logic        resp_valid,
    output logic [1:0]  resp_code,
    output logic [31:0] stat_mbox,
    output logic [31:0] stat_dbpw
);
    typedef struct packed {
        logic       valid;
        logic [1:0] code;
    } resp_t;

    logic [NUM_UNITS-1:0][CNT_W-1:0] unit_cnt;
    logic [NUM_UNITS-1:0] unit_fail, unit_err, unit_full, unit_empty;
    logic [UNIT_W-1:0]    tgt;
    logic                 respond, accept;
    logic [1:0]           code;
    resp_t                resp_d, resp_q;

    msg_admit_decide #(
        .DB_BUSY_RETRY(DB_BUSY_RETRY),
        .PW_BUSY_DROP (PW_BUSY_DROP)
    ) u_decide (
        .txn_valid  (txn_valid),
        .txn_kind   (txn_kind),
        .txn_mbox   (txn_mbox),
        .txn_size_ok(txn_size_ok),
        .ready      (unit_ready),
        .busy       (unit_busy),
        .failed     (unit_fail),
        .error      (unit_err),
        .full       (unit_full),
        .unit_idx   (tgt),
        .respond    (respond),
        .accept     (accept),
        .code       (code)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic hit;
        assign hit = (tgt == UNIT_W'(u));
        msg_admit_unit #(.DEPTH(DEPTH)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_i     (accept && hit),
            .pop_i     (pop_valid && (pop_unit == UNIT_W'(u))),
            .fault_i   (fault_valid && (fault_unit == UNIT_W'(u))),
            .clr_i     (clr_valid && (clr_unit == UNIT_W'(u))),
            .size_err_i(respond && !txn_size_ok && hit),
            .cnt_o     (unit_cnt[u]),
            .failed_o  (unit_fail[u]),
            .error_o   (unit_err[u]),
            .full_o    (unit_full[u]),
            .empty_o   (unit_empty[u])
        );
    end

    msg_admit_status u_status (
        .ready    (unit_ready),
        .full     (unit_full),
        .empty    (unit_empty),
        .busy     (unit_busy),
        .failed   (unit_fail),
        .error    (unit_err),
        .stat_mbox(stat_mbox),
        .stat_dbpw(stat_dbpw)
    );

    always_comb begin
        resp_d.valid = respond;
        resp_d.code  = respond ? code : resp_q.code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign resp_valid = resp_q.valid;
    assign resp_code  = resp_q.code;
endmodule

// File: rtl/msg_admit_chk.sv
module msg_admit_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  txn_valid,
    input logic [1:0]            txn_kind,
    input logic                  resp_valid,
    input logic [1:0]            resp_code,
    input logic                  clr_valid,
    input logic [2:0]            clr_unit,
    input logic [5:0][CNT_W-1:0] unit_cnt,
    input logic [5:0]            unit_err
);
    // R10: a response only follows a real transaction strobe
    a_r10_resp_needs_txn: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(txn_valid) && ($past(txn_kind) != 2'd3)));

    // R6: port-writes are accepted or dropped, never answered with error or retry
    a_r6_pw_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && ($past(txn_kind) == 2'd2)) |-> (resp_code == 2'd0 || resp_code == 2'd3));

    for (genvar u = 0; u < 6; u++) begin : g_chk
        // R5: occupancy never passes the depth
        a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            unit_cnt[u] <= CNT_W'(DEPTH));
        // R8: error flag is sticky until its own clear
        a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_err[u] && !(clr_valid && clr_unit == 3'(u))) |=> unit_err[u]);
    end
endmodule

bind msg_admit_ctrl msg_admit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_valid (txn_valid),
    .txn_kind  (txn_kind),
    .resp_valid(resp_valid),
    .resp_code (resp_code),
    .clr_valid (clr_valid),
    .clr_unit  (clr_unit),
    .unit_cnt  (unit_cnt),
    .unit_err  (unit_err)
);

// File: tb/tb_msg_admit_ctrl.sv
module tb_msg_admit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam bit DB_BR      = 1'b1;
    localparam bit PW_BD      = 1'b1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        txn_valid = 0, txn_size_ok = 1, pop_valid = 0, fault_valid = 0, clr_valid = 0;
    logic [1:0]  txn_kind = 0, txn_mbox = 0, resp_code;
    logic [5:0]  unit_ready = 6'h3F, unit_busy = 0;
    logic [2:0]  pop_unit = 0, fault_unit = 0, clr_unit = 0;
    logic        resp_valid;
    logic [31:0] stat_mbox, stat_dbpw;

    int checks = 0, errors = 0;
    int cnt[6];
    bit fl[6], er[6];

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_admit_ctrl #(.DEPTH(DEPTH), .DB_BUSY_RETRY(DB_BR), .PW_BUSY_DROP(PW_BD)) dut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_mbox(txn_mbox), .txn_size_ok(txn_size_ok), .unit_ready(unit_ready),
        .unit_busy(unit_busy), .pop_valid(pop_valid), .pop_unit(pop_unit),
        .fault_valid(fault_valid), .fault_unit(fault_unit), .clr_valid(clr_valid),
        .clr_unit(clr_unit), .resp_valid(resp_valid), .resp_code(resp_code),
        .stat_mbox(stat_mbox), .stat_dbpw(stat_dbpw));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] grp(input int u);
        return {unit_ready[u], cnt[u] == DEPTH, cnt[u] == 0, unit_busy[u], fl[u], er[u], 2'b00};
    endfunction

    function automatic logic [31:0] exp_mbox();
        return {grp(0), grp(1), grp(2), grp(3)};
    endfunction

    function automatic logic [31:0] exp_dbpw();
        return {grp(4), 16'h0000, grp(5)};
    endfunction

    function automatic int unit_of(input logic [1:0] k, input logic [1:0] mb);
        return (k == 2'd0) ? int'(mb) : (k == 2'd1) ? 4 : 5;
    endfunction

    // one cycle: drive, check status, predict response, update model, check response
    task automatic cycle(input bit v, input logic [1:0] k, input logic [1:0] mb, input bit sz,
                         input bit pv, input int pu, input bit fv, input int fu,
                         input bit cv, input int cu);
        int  u;
        bit  err, ret, blk, evalid, acc, canpop;
        logic [1:0] ecode;
        string tag;
        @(negedge clk);
        txn_valid = v; txn_kind = k; txn_mbox = mb; txn_size_ok = sz;
        pop_valid = pv; pop_unit = 3'(pu); fault_valid = fv; fault_unit = 3'(fu);
        clr_valid = cv; clr_unit = 3'(cu);
        #1;
        check(stat_mbox == exp_mbox(), "R1 mailbox status", stat_mbox, exp_mbox());
        check(stat_dbpw == exp_dbpw(), "R2 doorbell/port-write status", stat_dbpw, exp_dbpw());
        u      = unit_of(k, mb);
        evalid = v && (k != 2'd3);
        err    = !unit_ready[u] || fl[u] || er[u] || !sz;
        blk    = (u < 4) ? 1'b1 : (u == 4) ? DB_BR : PW_BD;
        ret    = (cnt[u] == DEPTH) || (unit_busy[u] && blk);
        if (u == 5)   ecode = (err || ret) ? 2'd3 : 2'd0;
        else if (err) ecode = 2'd2;
        else if (ret) ecode = 2'd1;
        else          ecode = 2'd0;
        if (u == 5)                          tag = "R6 port-write";
        else if (!err && unit_busy[u] && u == 4) tag = "R7 doorbell busy";
        else if (ecode == 2'd2)              tag = (er[u] || !sz) ? "R3/R8 error" : "R3 error";
        else if (ecode == 2'd1)              tag = "R4 retry";
        else                                 tag = "R5 accept";
        if (evalid && u == 5 && unit_busy[u] && !err) tag = "R7 port-write busy";
        acc    = evalid && (ecode == 2'd0);
        canpop = pv && (pu < 6) && (cnt[pu] > 0);
        if (cv && cu < 6) begin fl[cu] = 0; er[cu] = 0; end
        if (fv && fu < 6) fl[fu] = 1;
        if (evalid && !sz) er[u] = 1;
        if (acc) cnt[u]++;
        if (canpop) cnt[pu]--;
        @(posedge clk); #1;
        check(resp_valid == evalid, "R10 response strobe", 32'(resp_valid), 32'(evalid));
        if (evalid) check(resp_code == ecode, tag, 32'(resp_code), 32'(ecode));
        @(negedge clk);
        txn_valid = 0; pop_valid = 0; fault_valid = 0; clr_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) begin cnt[i] = 0; fl[i] = 0; er[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R11: reset state
        check(resp_valid == 1'b0, "R11 resp after reset", 32'(resp_valid), 32'd0);
        check(stat_mbox == 32'hA0A0A0A0, "R11 mailbox word after reset", stat_mbox, 32'hA0A0A0A0);
        check(stat_dbpw == 32'hA00000A0, "R11 dbpw word after reset", stat_dbpw, 32'hA00000A0);

        // R5/R4: fill mailbox 2, one more gets retry
        for (int i = 0; i <= DEPTH; i++) cycle(1, 2'd0, 2'd2, 1, 0, 0, 0, 0, 0, 0);
        // R9: push and pop together at full, then pops past zero
        cycle(1, 2'd0, 2'd2, 1, 1, 2, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) cycle(0, 2'd0, 2'd0, 1, 1, 2, 0, 0, 0, 0);
        check(stat_mbox[15:8] == 8'hA0, "R9 pop at zero keeps empty", 32'(stat_mbox[15:8]), 32'hA0);
        // R9: push and pop together at zero -> one
        cycle(1, 2'd0, 2'd2, 1, 1, 2, 0, 0, 0, 0);

        // R7: busy doorbell and busy port-write
        unit_busy = 6'b110000;
        cycle(1, 2'd1, 2'd0, 1, 0, 0, 0, 0, 0, 0);
        cycle(1, 2'd2, 2'd0, 1, 0, 0, 0, 0, 0, 0);
        unit_busy = 6'b000001;
        cycle(1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0);
        unit_busy = 0;

        // R6: fill port-write unit, then full and bad size are dropped
        for (int i = 0; i <= DEPTH; i++) cycle(1, 2'd2, 2'd0, 1, 0, 0, 0, 0, 0, 0);
        cycle(1, 2'd2, 2'd0, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 1, 5);

        // R8: bad size on mailbox 1 sticks, clear lifts it
        cycle(1, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
        cycle(1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0);
        check(stat_mbox[23:16] == 8'hA4, "R8 error flag sticky", 32'(stat_mbox[23:16]), 32'hA4);
        cycle(0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 1, 1);
        cycle(1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0);

        // R3: mailbox 3 full and failed -> error; set wins over clear
        for (int i = 0; i < DEPTH; i++) cycle(1, 2'd0, 2'd3, 1, 0, 0, 0, 0, 0, 0);
        cycle(0, 2'd0, 2'd0, 1, 0, 0, 1, 3, 1, 3);
        check(stat_mbox[7:0] == 8'hC8, "R8 fault set wins over clear", 32'(stat_mbox[7:0]), 32'hC8);
        cycle(1, 2'd0, 2'd3, 1, 0, 0, 0, 0, 0, 0);
        cycle(0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 1, 3);
        // R3: not ready mailbox 0
        unit_ready = 6'b111110;
        cycle(1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0);
        unit_ready = 6'h3F;
        // R10: kind 3 gives nothing
        cycle(1, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            unit_ready = {(($urandom % 10) != 0), (($urandom % 10) != 0), (($urandom % 10) != 0),
                          (($urandom % 10) != 0), (($urandom % 10) != 0), (($urandom % 10) != 0)};
            unit_busy  = 6'($urandom) & 6'($urandom) & 6'($urandom);
            cycle(($urandom % 10) < 7, 2'($urandom), 2'($urandom), ($urandom % 10) != 0,
                  ($urandom % 10) < 4, int'($urandom % 7), ($urandom % 30) == 0, int'($urandom % 6),
                  ($urandom % 10) == 0, int'($urandom % 6));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule